// File: doc/BRIEF.md
# USB High-Speed Chirp Negotiator (Peripheral Side)

This block is the peripheral-side sequencer that turns a bus reset into a decision about link speed. It watches the two-bit line state reported by the transceiver and a periodic time tick. When the bus has sat in single-ended zero long enough to count as a reset, it switches the transceiver into high-speed chirp operation. It then asks the transmit path to send a continuous Chirp K, and ends that transmission after the required dwell.

After its own chirp the block listens for the host's alternating K and J chirps. Each chirp counts only if it holds steady for a qualification interval. A full set of K-J pairs moves the transceiver into normal high-speed operation with high-speed termination. If the set does not arrive in time, or the own chirp cannot be completed within its deadline, the transceiver returns to full-speed settings. A status pair reports which outcome was reached.

All durations are counted in ticks of `tick`, so one tick per microsecond gives the usual time units. The transceiver control fields come out as plain levels, and the register writes that carry them to the transceiver are handled elsewhere.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: During and straight after reset: `xcvr_sel`=2'b01, `term_sel`=1, `op_mode`=2'b00, and `tx_req`, `tx_stop`, `hs_mode`, `settled` are all 0.
- R2: The handshake starts only when `line_state`=2'b00 (SE0) has stayed unchanged for at least `QUAL_TICKS` ticks. Any other value restarts the qualification, so repeated short SE0 bursts never start it.
- R3: On qualification the block drives `xcvr_sel`=2'b00 and `op_mode`=2'b10 while keeping `term_sel`=1, and raises `tx_req`. It holds `tx_req` until `tx_ack` is seen.
- R4: The chirp lasts `CHIRP_TICKS` ticks counted from the `tx_ack` cycle. It is ended by a single-cycle `tx_stop`, after which `op_mode` stays 2'b10 while the block listens.
- R5: If `CHIRP_MAX_TICKS` ticks pass after SE0 began before the chirp completes, the block abandons the handshake. It drops `tx_req` (or pulses `tx_stop` if already chirping) and settles at full speed.
- R6: Host chirps are K=2'b10 and J=2'b01. A symbol counts only after holding for `QUAL_TICKS` ticks. A K followed by a J forms one pair. A J not preceded by a K, or a second K in place of a J, clears the pair count. Other line codes and unqualified glitches are ignored.
- R7: After `HOST_PAIRS` pairs the block drives `xcvr_sel`=2'b00, `term_sel`=0, `op_mode`=2'b00, `hs_mode`=1, `settled`=1, and keeps this until reset.
- R8: If the pairs are not complete within `LISTEN_TICKS` ticks after the chirp ends, the block drives `xcvr_sel`=2'b01, `term_sel`=1, `op_mode`=2'b00, `hs_mode`=0, `settled`=1.
- R9: From the full-speed settled state, a newly qualified SE0 starts the handshake again.
- R10: All dwell and timeout counters advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base strobe, one cycle per time unit |
| line_state | input | 2 | Line state from the transceiver (00 SE0, 01 J, 10 K) |
| tx_ack | input | 1 | Transmit path has accepted the chirp command |
| tx_req | output | 1 | Request to start transmitting Chirp K |
| tx_stop | output | 1 | One-cycle request to end the chirp |
| xcvr_sel | output | 2 | Transceiver speed select (00 high speed, 01 full speed) |
| term_sel | output | 1 | Termination select (0 high-speed, 1 full-speed) |
| op_mode | output | 2 | Operating mode (00 normal, 10 chirp) |
| hs_mode | output | 1 | Handshake ended at high speed |
| settled | output | 1 | Handshake has reached an outcome |

## Verification
The host chirp counter is driven with clean alternating K/J trains, trains that begin with a J, and trains one pair short. These separate correct pair counting from off-by-one and start-symbol errors. Trains with a repeated K across a short SE0, or with sub-qualification glitches, show whether alternation is enforced and whether short symbols are filtered rather than counted. Reset qualification is tried with repeated short SE0 bursts and with a sparse tick, which tells a dwell measured in ticks from one measured in clock cycles. Random trains mixing long chirps and glitches are scored by a bench model of the pairing rule.

// File: rtl/hs_chirp_pkg.sv
package hs_chirp_pkg;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam logic [1:0] XS_HIGH = 2'b00;
  localparam logic [1:0] XS_FULL = 2'b01;
  localparam logic [1:0] OP_NORM = 2'b00;
  localparam logic [1:0] OP_CHRP = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CHIRP,
    ST_STOP,
    ST_ABORT,
    ST_LISTEN,
    ST_HS,
    ST_FS
  } neg_state_e;

endpackage

// File: rtl/hsc_tick_timer.sv
module hsc_tick_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (tick && (cnt_q != LIM))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == LIM);

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R10
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/hsc_pair_tracker.sv
module hsc_pair_tracker
  import hs_chirp_pkg::*;
#(
  parameter int PAIRS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sym_new,
  input  logic [1:0] sym,
  output logic       pairs_done
);
  localparam int PW = $clog2(PAIRS + 1);
  localparam logic [PW-1:0] PMAX = PW'(PAIRS);

  logic [PW-1:0] pairs_q, pairs_d;
  logic          want_j_q, want_j_d;

  always_comb begin
    pairs_d  = pairs_q;
    want_j_d = want_j_q;
    if (clr) begin
      pairs_d  = '0;
      want_j_d = 1'b0;
    end else if (sym_new) begin
      if (sym == LS_K) begin
        if (want_j_q) pairs_d = '0;
        want_j_d = 1'b1;
      end else if (sym == LS_J) begin
        if (want_j_q) begin
          if (pairs_q != PMAX) pairs_d = pairs_q + 1'b1;
        end else begin
          pairs_d = '0;
        end
        want_j_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pairs_q  <= '0;
      want_j_q <= 1'b0;
    end else begin
      pairs_q  <= pairs_d;
      want_j_q <= want_j_d;
    end
  end

  assign pairs_done = (pairs_q == PMAX);

  AST_PAIRS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pairs_q <= PMAX); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pairs_q == '0) && !want_j_q); // R6

endmodule

// File: rtl/hs_chirp_ctrl.sv
module hs_chirp_ctrl
  import hs_chirp_pkg::*;
#(
  parameter int QUAL_TICKS      = 3,
  parameter int CHIRP_TICKS     = 1000,
  parameter int CHIRP_MAX_TICKS = 7000,
  parameter int LISTEN_TICKS    = 2000,
  parameter int HOST_PAIRS      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_state,
  input  logic       tx_ack,
  output logic       tx_req,
  output logic       tx_stop,
  output logic [1:0] xcvr_sel,
  output logic       term_sel,
  output logic [1:0] op_mode,
  output logic       hs_mode,
  output logic       settled
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  neg_state_e st_q, st_d;

  // line state dwell qualification
  logic [1:0] ls_q;
  logic       ls_change, dwell_hit, line_ok, line_ok_q, sym_new;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q      <= LS_J;
      line_ok_q <= 1'b0;
    end else begin
      ls_q      <= line_state;
      line_ok_q <= line_ok;
    end
  end

  assign ls_change = (line_state != ls_q);
  assign line_ok   = dwell_hit && !ls_change;
  assign sym_new   = line_ok && !line_ok_q;

  hsc_tick_timer #(.LIMIT(QUAL_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_ni), .clr(ls_change), .tick(tick), .hit(dwell_hit));

  // deadline since SE0 began
  logic in_wait, in_send, elapsed_clr, elapsed_hit;
  assign in_wait     = (st_q == ST_IDLE) || (st_q == ST_FS);
  assign in_send     = (st_q == ST_REQ) || (st_q == ST_CHIRP);
  assign elapsed_clr = !in_send && !(in_wait && (line_state == LS_SE0));

  hsc_tick_timer #(.LIMIT(CHIRP_MAX_TICKS)) u_elapsed (
    .clk(clk), .rst_n(rst_ni), .clr(elapsed_clr), .tick(tick), .hit(elapsed_hit));

  // own chirp length
  logic chirp_hit;
  hsc_tick_timer #(.LIMIT(CHIRP_TICKS)) u_chirp (
    .clk(clk), .rst_n(rst_ni), .clr(st_q != ST_CHIRP), .tick(tick), .hit(chirp_hit));

  // listen window
  logic listen_hit;
  hsc_tick_timer #(.LIMIT(LISTEN_TICKS)) u_listen (
    .clk(clk), .rst_n(rst_ni), .clr(st_q != ST_LISTEN), .tick(tick), .hit(listen_hit));

  // host chirp pairing
  logic pairs_done;
  hsc_pair_tracker #(.PAIRS(HOST_PAIRS)) u_pairs (
    .clk(clk), .rst_n(rst_ni), .clr(st_q != ST_LISTEN),
    .sym_new(sym_new), .sym(line_state), .pairs_done(pairs_done));

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_FS: if (line_ok && (line_state == LS_SE0)) st_d = ST_REQ;
      ST_REQ: begin
        if (elapsed_hit)  st_d = ST_FS;
        else if (tx_ack)  st_d = ST_CHIRP;
      end
      ST_CHIRP: begin
        if (chirp_hit)        st_d = ST_STOP;
        else if (elapsed_hit) st_d = ST_ABORT;
      end
      ST_STOP:  st_d = ST_LISTEN;
      ST_ABORT: st_d = ST_FS;
      ST_LISTEN: begin
        if (pairs_done)      st_d = ST_HS;
        else if (listen_hit) st_d = ST_FS;
      end
      ST_HS:   st_d = ST_HS;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // output decode
  always_comb begin
    tx_req   = 1'b0;
    tx_stop  = 1'b0;
    xcvr_sel = XS_FULL;
    term_sel = 1'b1;
    op_mode  = OP_NORM;
    hs_mode  = 1'b0;
    settled  = 1'b0;
    unique case (st_q)
      ST_REQ: begin
        tx_req = 1'b1; xcvr_sel = XS_HIGH; op_mode = OP_CHRP;
      end
      ST_CHIRP, ST_LISTEN: begin
        xcvr_sel = XS_HIGH; op_mode = OP_CHRP;
      end
      ST_STOP, ST_ABORT: begin
        tx_stop = 1'b1; xcvr_sel = XS_HIGH; op_mode = OP_CHRP;
      end
      ST_HS: begin
        xcvr_sel = XS_HIGH; term_sel = 1'b0; hs_mode = 1'b1; settled = 1'b1;
      end
      ST_FS: settled = 1'b1;
      default: ;
    endcase
  end

  AST_START_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(tx_req) |-> ($past(line_state) == LS_SE0)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_req && !tx_ack && !elapsed_hit) |=> tx_req); // R3
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    tx_stop |=> !tx_stop); // R4
  AST_HS_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    hs_mode |=> (hs_mode && !term_sel && (op_mode == OP_NORM))); // R7
  AST_FS_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (listen_hit && !pairs_done && (st_q == ST_LISTEN)) |=> (settled && !hs_mode)); // R8

endmodule

// File: tb/tb_hs_chirp_ctrl.sv
module tb_hs_chirp_ctrl;
  localparam int QUAL = 3, CHIRP = 40, CMAX = 120, WIN = 200, PAIRS = 3;
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, tx_ack = 1'b0;
  logic [1:0] line_state = J;
  logic tx_req, tx_stop, term_sel, hs_mode, settled;
  logic [1:0] xcvr_sel, op_mode;

  int checks = 0, errors = 0, cyc = 0;
  bit sparse = 1'b0;
  logic [1:0] sym_a [16];
  int len_a [16];

  always #2.5 clk = ~clk;

  hs_chirp_ctrl #(.QUAL_TICKS(QUAL), .CHIRP_TICKS(CHIRP), .CHIRP_MAX_TICKS(CMAX),
                  .LISTEN_TICKS(WIN), .HOST_PAIRS(PAIRS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state), .tx_ack(tx_ack),
    .tx_req(tx_req), .tx_stop(tx_stop), .xcvr_sel(xcvr_sel), .term_sel(term_sel),
    .op_mode(op_mode), .hs_mode(hs_mode), .settled(settled));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= sparse ? ((cyc % 4) == 0) : 1'b1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fields(string req, logic [1:0] xs, logic ts, logic [1:0] om, logic hs, logic st);
    chk(xcvr_sel == xs, {req, " xcvr_sel"}, xcvr_sel, xs);
    chk(term_sel == ts, {req, " term_sel"}, term_sel, ts);
    chk(op_mode == om, {req, " op_mode"}, op_mode, om);
    chk(hs_mode == hs, {req, " hs_mode"}, hs_mode, hs);
    chk(settled == st, {req, " settled"}, settled, st);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_state = J; tx_ack = 1'b0; sparse = 1'b0;
    step(3);
    fields("R1", 2'b01, 1'b1, 2'b00, 1'b0, 1'b0);
    chk(!tx_req && !tx_stop, "R1 tx", {tx_req, tx_stop}, 0);
    rst_n = 1'b1;
    step(4);
  endtask

  // SE0, own chirp, then a short SE0 gap before the host train
  task automatic run_chirp();
    int n;
    line_state = SE0; step(10);
    chk(tx_req == 1'b1, "R2 start", tx_req, 1);
    fields("R3", 2'b00, 1'b1, 2'b10, 1'b0, 1'b0);
    line_state = K; step(3);
    chk(tx_req == 1'b1, "R3 hold", tx_req, 1);
    tx_ack = 1'b1; step(1); tx_ack = 1'b0;
    n = 0;
    while (!tx_stop && n < 100) begin step(1); n++; end
    chk(n >= CHIRP - 2 && n <= CHIRP + 4, "R4 length", n, CHIRP + 1);
    step(1);
    chk(!tx_stop && op_mode == 2'b10, "R4 pulse", {tx_stop, op_mode}, 2);
    line_state = SE0; step(2);
  endtask

  function automatic bit model_hs(int n);
    bit wj = 1'b0;
    int p = 0;
    for (int i = 0; i < n; i++) begin
      if ((len_a[i] >= 6 || i == n - 1) && (sym_a[i] == K || sym_a[i] == J)) begin
        if (sym_a[i] == K) begin
          if (wj) p = 0;
          wj = 1'b1;
        end else begin
          if (wj) p++; else p = 0;
          wj = 1'b0;
        end
        if (p >= PAIRS) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic play(int n, string req);
    int used = 2;
    bit e;
    for (int i = 0; i < n; i++) begin
      line_state = sym_a[i]; step(len_a[i]); used += len_a[i];
    end
    step(WIN + 30 - used);
    e = model_hs(n);
    if (e) fields(req, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1);
    else   fields(req, 2'b01, 1'b1, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic alt(int n, logic [1:0] first);
    for (int i = 0; i < n; i++) begin
      sym_a[i] = (i % 2 == 0) ? first : ((first == K) ? J : K);
      len_a[i] = 8;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R2: short SE0 bursts broken by J never qualify
    for (int i = 0; i < 5; i++) begin
      line_state = SE0; step(2); line_state = J; step(1);
    end
    step(4);
    chk(tx_req == 1'b0, "R2 short bursts", tx_req, 0);
    fields("R2", 2'b01, 1'b1, 2'b00, 1'b0, 1'b0);

    // R6 R7: clean K-J train
    run_chirp(); alt(6, K); play(6, "R7 clean train");

    // R8: one pair short, then new SE0 restarts (R9)
    do_reset(); run_chirp(); alt(5, K); play(5, "R8 short train");
    line_state = SE0; step(10);
    chk(tx_req == 1'b1, "R9 restart", tx_req, 1);

    // R6: leading J is not a pair
    do_reset(); run_chirp(); alt(7, J); play(7, "R6 leading J");

    // R6: repeated K across a short SE0 clears the count
    do_reset(); run_chirp();
    sym_a[0] = K; len_a[0] = 8; sym_a[1] = J; len_a[1] = 8;
    sym_a[2] = K; len_a[2] = 8; sym_a[3] = SE0; len_a[3] = 1;
    sym_a[4] = K; len_a[4] = 8; sym_a[5] = J; len_a[5] = 8;
    sym_a[6] = K; len_a[6] = 8; sym_a[7] = J; len_a[7] = 8;
    play(8, "R6 repeated K");

    // R6: glitches of code 11 between chirps are ignored
    do_reset(); run_chirp();
    sym_a[0] = K; len_a[0] = 8; sym_a[1] = 2'b11; len_a[1] = 2;
    sym_a[2] = K; len_a[2] = 8; sym_a[3] = J; len_a[3] = 8;
    sym_a[4] = K; len_a[4] = 8; sym_a[5] = J; len_a[5] = 8;
    sym_a[6] = K; len_a[6] = 8; sym_a[7] = J; len_a[7] = 8;
    play(8, "R6 glitch");

    // R5: no acknowledge, deadline abandons the handshake
    do_reset();
    line_state = SE0; step(10);
    chk(tx_req == 1'b1, "R5 request", tx_req, 1);
    line_state = J; step(CMAX + 30);
    chk(tx_req == 1'b0, "R5 dropped", tx_req, 0);
    fields("R5", 2'b01, 1'b1, 2'b00, 1'b0, 1'b1);

    // R10: sparse tick stretches the qualification
    do_reset(); sparse = 1'b1;
    line_state = SE0; step(8); line_state = J; step(2);
    chk(tx_req == 1'b0, "R10 few ticks", tx_req, 0);
    line_state = SE0; step(24);
    chk(tx_req == 1'b1, "R10 enough ticks", tx_req, 1);
    sparse = 1'b0;

    // random trains scored by the pairing model (R6 R7 R8)
    for (int r = 0; r < 14; r++) begin
      int n;
      logic [1:0] prev, last_long, s;
      do_reset(); run_chirp();
      n = 4 + int'($urandom % 7);
      prev = SE0; last_long = J;
      for (int i = 0; i < n; i++) begin
        if (i == n - 1 || ($urandom % 4) != 0) begin
          s = (($urandom % 5) == 0) ? last_long : ((last_long == K) ? J : K);
          if (s == prev) s = (s == K) ? J : K;
          len_a[i] = 6 + int'($urandom % 7);
          last_long = s;
        end else begin
          do s = 2'($urandom); while (s == prev);
          len_a[i] = 1 + int'($urandom % 2);
        end
        sym_a[i] = s; prev = s;
      end
      play(n, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule